// File: doc/BRIEF.md
# Prioritized Frame Receiver with Checksum Rollback

This block takes a byte stream, one byte per accepted transfer, in which frames are delimited by a start-of-frame strobe. Each frame carries a two-byte header, then a payload of 1 to 256 bytes, then a two-byte checksum. The header is sent most significant byte first. The block decodes the header and keeps a running checksum over the frame. It writes the payload into a staging buffer chosen by the header's priority class. The payload is released to the output stream only once the trailing checksum has been compared and found equal.

On a checksum mismatch, the staged bytes of the frame are withdrawn by returning the class write pointer to its last committed position. The block then raises a one-cycle negative-acknowledge pulse and counts the event. There are three classes, each with its own staging buffer: control, time-sensitive and bulk. The shared output port always drains committed control bytes first, then time-sensitive bytes, then bulk bytes. Every output byte carries its class and its signal type.

Top module: `prio_frame_rx`

## Requirements
- R1: After reset, `out_valid`, `nak`, `err_count` and `drop_count` are 0 and `in_ready` is 1.
- R2: The header is a 16-bit word {first byte, second byte}. Bits [15:14] select the class (00 control, 01 time-sensitive, 10 bulk), bits [13:8] are the signal type, and bits [7:0] are the payload length minus one. A good frame's payload leaves the output in arrival order, tagged `out_cls` = 0, 1 or 2 for those classes and `out_type` = bits [13:8].
- R3: The checksum field, sent high byte first, must equal the 16-bit ones'-complement sum (end-around carry) of the header word and the payload taken as big-endian 16-bit words. No payload byte of a frame is visible at the output before its second checksum byte is accepted.
- R4: On a mismatch in classes 0 to 2, `nak` is high for exactly one cycle, the cycle right after the second checksum byte is accepted. No byte of that frame ever reaches the output. `err_count` and `drop_count` each increase by one.
- R5: A frame with class 11 is consumed to its end, writes nothing and raises no `nak`. It increments `drop_count` but not `err_count`, whatever its checksum.
- R6: A start-of-frame byte accepted while a frame is in progress aborts that frame. The aborted frame produces no output and no `nak`, and `drop_count` increases by one. The strobed byte is taken as the first header byte of a new frame.
- R7: Bytes accepted outside a frame without the start-of-frame strobe are ignored: they produce no output and change no counter.
- R8: Whenever committed class-0 bytes are pending, the output presents class 0. Class 1 is presented before class 2. Byte order within a class is kept, and a class-0 commit can interleave inside a class-1 drain.
- R9: `in_ready` falls only during a payload byte whose class buffer holds DEPTH bytes, committed or staged. It rises again once the output drains space.
- R10: `err_count` and `drop_count` saturate at 2^CNT_W-1.
- R11: Payloads of odd length are padded with a zero low byte for the checksum. Lengths 1 and 256 are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_sof | input | 1 | Marks the first header byte of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Committed payload byte available |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_cls | output | 2 | Class of the output byte |
| out_type | output | 6 | Signal type of the output byte's frame |
| out_data | output | 8 | Output payload byte |
| nak | output | 1 | One-cycle negative-acknowledge on checksum mismatch |
| err_count | output | CNT_W | Saturating checksum-error count |
| drop_count | output | CNT_W | Saturating dropped-frame count |

## Verification
Two functions can act in the same cycle: the commit of a control-class frame, and the drain of a time-sensitive frame that is already on the output. The bench holds the output stalled while a 200-byte time-sensitive frame commits, then releases the output and at once sends a short control frame. The control frame's commit therefore lands partway through the drain. The captured stream is judged in three ways: the control bytes must form one contiguous run that starts after the first time-sensitive byte; the time-sensitive bytes must stay complete and in order around that run; and neither frame may lose or repeat a byte.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  localparam int NCLS   = 3;
  localparam int BYTE_W = 8;
  localparam int TYPE_W = 6;
  localparam int SLOT_W = TYPE_W + BYTE_W;

  localparam logic [1:0] CLS_RSV = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HLO,
    ST_PAY,
    ST_CK0,
    ST_CK1
  } rx_state_t;

  // ones'-complement 16-bit add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'b0, s[16]};
  endfunction

  function automatic logic [1:0] hdr_class(input logic [7:0] hi);
    return hi[7:6];
  endfunction

  function automatic logic [TYPE_W-1:0] hdr_type(input logic [7:0] hi);
    return hi[5:0];
  endfunction

endpackage

// File: rtl/pfr_sat_cnt.sv
module pfr_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (inc && !(&q))
      q <= q + W'(1);
  end
endmodule

// File: rtl/pfr_stage.sv
module pfr_stage import pfr_pkg::*; #(
  parameter int DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              commit,
  input  logic              rollback,
  input  logic              rd_en,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              avail,
  output logic              full
);
  localparam int AW = $clog2(DEPTH);

  logic [SLOT_W-1:0] mem [DEPTH];
  logic [AW:0] wr_p, cm_p, rd_p;
  logic [AW:0] used;

  assign used    = wr_p - rd_p;
  assign full    = used[AW];
  assign avail   = (rd_p != cm_p);
  assign rd_slot = mem[rd_p[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_p[AW-1:0]] <= wr_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0;
      cm_p <= '0;
      rd_p <= '0;
    end else begin
      if (rollback)
        wr_p <= cm_p;
      else if (wr_en)
        wr_p <= wr_p + (AW+1)'(1);
      if (commit)
        cm_p <= wr_p;
      if (rd_en)
        rd_p <= rd_p + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/pfr_arb.sv
module pfr_arb import pfr_pkg::*; (
  input  logic [NCLS-1:0] avail,
  input  logic            ready,
  output logic            valid,
  output logic [1:0]      sel,
  output logic [NCLS-1:0] pop
);
  always_comb begin
    sel = 2'd0;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (avail[i])
        sel = 2'(i);
    end
  end

  assign valid = |avail;

  always_comb begin
    for (int i = 0; i < NCLS; i++)
      pop[i] = valid && ready && (sel == 2'(i));
  end
endmodule

// File: rtl/pfr_parser.sv
module pfr_parser import pfr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [7:0]        in_data,
  input  logic [NCLS-1:0]   full,
  output logic              in_ready,
  output logic              wr_en,
  output logic [1:0]        wr_cls,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              commit,
  output logic              rollback,
  output logic              ev_bad,
  output logic              ev_drop,
  output logic              in_payload
);
  rx_state_t         st;
  logic [1:0]        cls;
  logic [TYPE_W-1:0] typ;
  logic [7:0]        len_m1, cnt, hdr_hi, hi_pend, ck_hi;
  logic [15:0]       acc, final_sum;
  logic              accept, cls_ok, abort, ck_done, sum_ok, good, full_sel;

  assign cls_ok = (cls != CLS_RSV);

  always_comb begin
    case (cls)
      2'd0:    full_sel = full[0];
      2'd1:    full_sel = full[1];
      2'd2:    full_sel = full[2];
      default: full_sel = 1'b0;
    endcase
  end

  assign in_payload = (st == ST_PAY);
  assign in_ready   = !(in_payload && cls_ok && full_sel);
  assign accept     = in_valid && in_ready;
  assign abort      = accept && in_sof && (st != ST_IDLE);
  assign ck_done    = accept && !in_sof && (st == ST_CK1);

  // odd length (len_m1 even) needs a zero-padded last word
  assign final_sum = len_m1[0] ? acc : oc_add(acc, {hi_pend, 8'h00});
  assign sum_ok    = (final_sum == {ck_hi, in_data});
  assign good      = ck_done && cls_ok && sum_ok;

  assign commit   = good;
  assign rollback = abort || (ck_done && !good);
  assign ev_bad   = ck_done && cls_ok && !sum_ok;
  assign ev_drop  = abort || (ck_done && !good);
  assign wr_en    = accept && !in_sof && in_payload && cls_ok;
  assign wr_cls   = cls;
  assign wr_slot  = {typ, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cls     <= 2'd0;
      typ     <= '0;
      len_m1  <= '0;
      cnt     <= '0;
      hdr_hi  <= '0;
      hi_pend <= '0;
      ck_hi   <= '0;
      acc     <= '0;
    end else if (accept) begin
      if (in_sof) begin
        hdr_hi <= in_data;
        st     <= ST_HLO;
      end else begin
        case (st)
          ST_HLO: begin
            cls    <= hdr_class(hdr_hi);
            typ    <= hdr_type(hdr_hi);
            len_m1 <= in_data;
            acc    <= {hdr_hi, in_data};
            cnt    <= '0;
            st     <= ST_PAY;
          end
          ST_PAY: begin
            cnt <= cnt + 8'd1;
            if (!cnt[0])
              hi_pend <= in_data;
            else
              acc <= oc_add(acc, {hi_pend, in_data});
            if (cnt == len_m1)
              st <= ST_CK0;
          end
          ST_CK0: begin
            ck_hi <= in_data;
            st    <= ST_CK1;
          end
          ST_CK1:  st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_frame_rx.sv
module prio_frame_rx import pfr_pkg::*; #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_cls,
  output logic [5:0]       out_type,
  output logic [7:0]       out_data,
  output logic             nak,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] drop_count
);
  logic              wr_en, commit, rollback, ev_bad, ev_drop, in_payload;
  logic [1:0]        wr_cls;
  logic [SLOT_W-1:0] wr_slot;
  logic [NCLS-1:0]   full, avail, pop;
  logic [SLOT_W-1:0] rd_slot [NCLS];
  logic [SLOT_W-1:0] sel_slot;

  pfr_parser u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .full(full), .in_ready(in_ready), .wr_en(wr_en),
    .wr_cls(wr_cls), .wr_slot(wr_slot), .commit(commit),
    .rollback(rollback), .ev_bad(ev_bad), .ev_drop(ev_drop),
    .in_payload(in_payload)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    pfr_stage #(.DEPTH(DEPTH)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && (wr_cls == 2'(c))),
      .wr_slot(wr_slot),
      .commit(commit && (wr_cls == 2'(c))),
      .rollback(rollback),
      .rd_en(pop[c]),
      .rd_slot(rd_slot[c]),
      .avail(avail[c]),
      .full(full[c])
    );
  end

  pfr_arb u_arb (
    .avail(avail), .ready(out_ready), .valid(out_valid),
    .sel(out_cls), .pop(pop)
  );

  always_comb begin
    case (out_cls)
      2'd1:    sel_slot = rd_slot[1];
      2'd2:    sel_slot = rd_slot[2];
      default: sel_slot = rd_slot[0];
    endcase
  end

  assign out_data = sel_slot[BYTE_W-1:0];
  assign out_type = sel_slot[SLOT_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n)
      nak <= 1'b0;
    else
      nak <= ev_bad;
  end

  pfr_sat_cnt #(.W(CNT_W)) u_err  (.clk(clk), .rst_n(rst_n), .inc(ev_bad),  .q(err_count));
  pfr_sat_cnt #(.W(CNT_W)) u_drop (.clk(clk), .rst_n(rst_n), .inc(ev_drop), .q(drop_count));
endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nak,
  input logic             in_ready,
  input logic             in_payload,
  input logic             out_valid,
  input logic [1:0]       out_cls,
  input logic [2:0]       avail,
  input logic [CNT_W-1:0] err_count,
  input logic [CNT_W-1:0] drop_count
);
  // R4: negative-acknowledge never lasts two cycles
  a_r4_nak_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    nak |=> !nak);

  // R4: error counter only moves together with a nak pulse
  a_r4_err_with_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> nak);

  // R8: pending control bytes own the output
  a_r8_ctrl_first: assert property (@(posedge clk) disable iff (!rst_n)
    avail[0] |-> (out_valid && out_cls == 2'd0));

  // R9: stalls happen only in the payload phase
  a_r9_stall_payload: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> in_payload);

  // R10: saturated counters stay saturated
  a_r10_err_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (&err_count) |=> (&err_count));

  a_r10_drop_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (&drop_count) |=> (&drop_count));
endmodule

bind prio_frame_rx pfr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nak(nak), .in_ready(in_ready),
  .in_payload(in_payload), .out_valid(out_valid), .out_cls(out_cls),
  .avail(avail), .err_count(err_count), .drop_count(drop_count)
);

// File: tb/sim_prio_frame_rx.sv
module sim_prio_frame_rx;
  localparam int DEPTH = 256;
  localparam int CW    = 4;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
  logic [7:0]    in_data = '0;
  logic          in_ready, out_valid, nak;
  logic [1:0]    out_cls;
  logic [5:0]    out_type;
  logic [7:0]    out_data;
  logic [CW-1:0] err_count, drop_count;

  prio_frame_rx #(.DEPTH(DEPTH), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_cls(out_cls), .out_type(out_type),
    .out_data(out_data), .nak(nak), .err_count(err_count),
    .drop_count(drop_count)
  );

  int n_chk = 0, n_err = 0;
  int nak_cnt = 0, nak_wide = 0;
  int e_err = 0, e_drop = 0, e_nak = 0;
  bit nak_prev = 0, done = 0;
  logic [15:0] gq[$];
  logic [15:0] ex0[$], ex1[$], ex2[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // output and nak monitor, sampled late in the low phase
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (out_valid && out_ready) gq.push_back({out_cls, out_type, out_data});
      if (nak) nak_cnt++;
      if (nak && nak_prev) nak_wide++;
      nak_prev = nak;
    end
  end

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic set_ready(input bit v);
    @(negedge clk);
    #1 out_ready = v;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit sof);
    in_valid = 1'b1; in_data = b; in_sof = sof;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send_frame(input int cls, input int typ, input int len,
                            input bit bad, input int seed, input bit probe);
    logic [7:0] pl [256];
    logic [15:0] hdr, ck;
    int unsigned s;
    hdr = {2'(cls), 6'(typ), 8'(len - 1)};
    for (int i = 0; i < len; i++) pl[i] = 8'((seed * 29) + i * 13 + (i >> 3));
    s = hdr;
    for (int i = 0; i < len; i += 2)
      s += {pl[i], (i + 1 < len) ? pl[i + 1] : 8'h00};
    while (s >> 16) s = (s & 32'hFFFF) + (s >> 16);
    ck = 16'(s);
    if (bad) ck = ck ^ 16'h0101;
    send_byte(hdr[15:8], 1'b1);
    send_byte(hdr[7:0], 1'b0);
    if (probe) begin
      in_valid = 1'b1; in_data = pl[0];
      chk(in_ready == 1'b0, "R9", "in_ready with full buffer", int'(in_ready), 0);
      in_valid = 1'b0;
      set_ready(1'b1);
    end
    for (int i = 0; i < len; i++) send_byte(pl[i], 1'b0);
    send_byte(ck[15:8], 1'b0);
    chk(gq.size() == 0 || out_ready, "R3", "output before checksum", gq.size(), 0);
    send_byte(ck[7:0], 1'b0);
    if (cls < 3 && bad) begin
      chk(nak == 1'b1, "R4", "nak after last checksum byte", int'(nak), 1);
      e_err++; e_drop++; e_nak++;
    end else if (cls == 3) begin
      e_drop++;
    end
    if (!bad && cls < 3)
      for (int i = 0; i < len; i++) begin
        if (cls == 0) ex0.push_back({2'(cls), 6'(typ), pl[i]});
        if (cls == 1) ex1.push_back({2'(cls), 6'(typ), pl[i]});
        if (cls == 2) ex2.push_back({2'(cls), 6'(typ), pl[i]});
      end
  endtask

  task automatic drain();
    int quiet = 0;
    for (int i = 0; i < 3000 && quiet < 4; i++) begin
      @(negedge clk);
      if (out_valid) quiet = 0; else quiet++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_all(input string rq, input string what);
    logic [15:0] ex[$];
    int bad_at = -1;
    ex = {ex0, ex1, ex2};
    if (ex.size() != gq.size()) bad_at = 99999;
    else for (int i = 0; i < ex.size(); i++) if (ex[i] != gq[i] && bad_at < 0) bad_at = i;
    chk(bad_at < 0, rq, what, gq.size(), ex.size());
    ex0.delete(); ex1.delete(); ex2.delete(); gq.delete();
  endtask

  task automatic cmp_counts(input string rq);
    chk(int'(err_count) == sat(e_err), rq, "err_count", int'(err_count), sat(e_err));
    chk(int'(drop_count) == sat(e_drop), rq, "drop_count", int'(drop_count), sat(e_drop));
    chk(nak_cnt == e_nak, rq, "nak pulses", nak_cnt, e_nak);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lens [6] = '{1, 2, 3, 7, 255, 256};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1", "out_valid", int'(out_valid), 0);
    chk(nak == 0, "R1", "nak", int'(nak), 0);
    chk(err_count == 0 && drop_count == 0, "R1", "counters", int'(drop_count), 0);
    chk(in_ready == 1, "R1", "in_ready", int'(in_ready), 1);

    // R2 R3 R11 sweep over classes and lengths
    for (int c = 0; c < 3; c++)
      for (int l = 0; l < 6; l++) begin
        send_frame(c, (c * 17 + l * 5) % 64, lens[l], 1'b0, c * 8 + l, 1'b0);
        drain();
        cmp_all((lens[l] % 2 == 1) ? "R11" : "R2", "good frame stream");
      end
    cmp_counts("R3");

    // R4 mismatch per class
    for (int c = 0; c < 3; c++) begin
      send_frame(c, 9, 6 + c, 1'b1, 40 + c, 1'b0);
      drain();
      cmp_all("R4", "bad frame output");
      cmp_counts("R4");
    end

    // R5 reserved class, good and bad checksum
    send_frame(3, 1, 4, 1'b0, 50, 1'b0);
    send_frame(3, 2, 5, 1'b1, 51, 1'b0);
    drain();
    cmp_all("R5", "reserved output");
    cmp_counts("R5");

    // R6 abort by start-of-frame in mid payload
    send_byte(8'h45, 1'b1);
    send_byte(8'h09, 1'b0);
    for (int i = 0; i < 4; i++) send_byte(8'(i + 3), 1'b0);
    e_drop++;
    send_frame(0, 33, 5, 1'b0, 60, 1'b0);
    drain();
    cmp_all("R6", "frame after abort");
    cmp_counts("R6");

    // R7 stray bytes outside a frame
    for (int i = 0; i < 3; i++) send_byte(8'hA5 ^ 8'(i), 1'b0);
    send_frame(1, 12, 4, 1'b0, 70, 1'b0);
    drain();
    cmp_all("R7", "stray bytes ignored");
    cmp_counts("R7");

    // R8 priority with output stalled
    set_ready(1'b0);
    send_frame(2, 3, 3, 1'b0, 80, 1'b0);
    send_frame(1, 4, 4, 1'b0, 81, 1'b0);
    send_frame(0, 5, 5, 1'b0, 82, 1'b0);
    chk(gq.size() == 0, "R8", "nothing drained while stalled", gq.size(), 0);
    set_ready(1'b1);
    drain();
    cmp_all("R8", "control then time-sensitive then bulk");

    // R8 control commit lands inside a time-sensitive drain
    set_ready(1'b0);
    send_frame(1, 6, 200, 1'b0, 90, 1'b0);
    set_ready(1'b1);
    send_frame(0, 7, 4, 1'b0, 91, 1'b0);
    drain();
    begin
      int first_a = -1, na = 0, ia = 0, ib = 0, okay = 1;
      for (int i = 0; i < gq.size(); i++) begin
        if (gq[i][15:14] == 2'd0) begin
          if (first_a < 0) first_a = i;
          if (i != first_a + na) okay = 0;
          if (ia >= ex0.size() || gq[i] != ex0[ia]) okay = 0;
          na++; ia++;
        end else begin
          if (ib >= ex1.size() || gq[i] != ex1[ib]) okay = 0;
          ib++;
        end
      end
      chk(first_a > 0 && first_a < 200, "R8", "control run position", first_a, 100);
      chk(okay == 1 && ia == 4 && ib == 200, "R8", "interleaved stream", ib, 200);
      ex0.delete(); ex1.delete(); gq.delete();
    end

    // R9 backpressure on a full bulk buffer
    set_ready(1'b0);
    send_frame(2, 8, 256, 1'b0, 100, 1'b0);
    send_frame(2, 8, 5, 1'b0, 101, 1'b1);
    drain();
    cmp_all("R9", "stream after stall");

    // R10 saturation
    for (int i = 0; i < 14; i++) send_frame(0, 1, 1, 1'b1, 110 + i, 1'b0);
    drain();
    cmp_counts("R10");
    chk(int'(err_count) == CMAX, "R10", "err saturated", int'(err_count), CMAX);
    chk(nak_wide == 0, "R4", "nak wider than one cycle", nak_wide, 0);
    finish_run();
  end
endmodule